// File: doc/BRIEF.md
# Symmetric FIR Pre-Adder Cell

This block is one multiply-accumulate cell for a symmetric FIR filter. Each clock it takes one sample from the forward path and one from the reverse path. Each sample can be forced to zero on its own. The cell adds the two samples, multiplies the sum by a coefficient and adds the product to a running sum. Symmetric taps share one multiplier this way, because the two samples that use the same coefficient are added before the multiply.

The cell holds 32 coefficient sets, and a 5-bit select chooses which one is in use. A processor loads the sets through a separate write port that has its own strobe. The accumulate enable decides when a sum ends. While it is high, products keep adding into the sum. When it is low, the finished sum moves into an output holding register, a valid pulse is raised, and a new sum starts from the current product.

Top module: `fir_symcell`

## Requirements
- R1: While rst_ni is low, and after it is released, res_o is 0 and res_vld_o is 0. All coefficient sets are 0 after reset. No valid pulse appears until a low accumulate enable has been captured.
- R2: When fwd_en_ni is 1, the forward operand of the pre-adder is 0. When it is 0, the operand is fwd_i read as 10-bit two's complement.
- R3: When rev_en_ni is 1, the reverse operand of the pre-adder is 0. When it is 0, the operand is rev_i read as 10-bit two's complement.
- R4: The product is (forward operand + reverse operand) times the selected coefficient. The sum is 11-bit signed, the coefficient is 10-bit two's complement, and the 21-bit signed product is sign-extended to 28 bits.
- R5: On a rising edge of wr_clk_i, if wr_addr_i[8:5] is 0, wr_data_i is stored as the coefficient of set wr_addr_i[4:0].
- R6: A write with wr_addr_i[8:5] not 0 changes no coefficient.
- R7: csel_i is captured on the same clk_i edge as the samples. The product for those samples uses the set that csel_i named at that edge.
- R8: When the captured accumulate enable is 1, the product is added to the running sum.
- R9: When the captured accumulate enable is 0, the running sum moves to res_o, and the sum restarts from that cycle's product alone.
- R10: res_o changes only on a dump. res_vld_o is 1 for exactly the one cycle in which res_o is updated.
- R11: Inputs captured at clk_i edge k first affect the running sum at edge k+2. A low acc_en_i captured at edge k updates res_o and pulses res_vld_o at edge k+2.
- R12: The running sum is 28 bits wide and wraps modulo 2^28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Datapath clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwd_i | input | 10 | Forward-path sample, two's complement |
| rev_i | input | 10 | Reverse-path sample, two's complement |
| fwd_en_ni | input | 1 | Forward operand enable, active low |
| rev_en_ni | input | 1 | Reverse operand enable, active low |
| csel_i | input | 5 | Coefficient set select |
| acc_en_i | input | 1 | 1 = accumulate, 0 = dump and restart |
| wr_clk_i | input | 1 | Coefficient write strobe, rising edge |
| wr_addr_i | input | 9 | Write address; [8:5] must be 0, [4:0] is the set |
| wr_data_i | input | 10 | Coefficient value to write |
| res_o | output | 28 | Output holding register |
| res_vld_o | output | 1 | One-cycle pulse when res_o updates |

## Verification
The hardest case to reach is wraparound of the running sum. The largest product is 2^19, so the sum crosses 2^28 only after more than 512 accumulations with nothing dumped in between. The bench loads the most negative coefficient and drives both samples at their most negative value. It holds the accumulate enable high for 600 cycles and then checks the dumped value against the wrapped result. A second case the bench reaches on purpose is a write whose upper address bits are not zero: it streams samples through that coefficient set afterwards, so an ignored write shows up at res_o.

// File: rtl/fir_cell_pkg.sv
package fir_cell_pkg;
  localparam int unsigned DATA_W = 10;
  localparam int unsigned COEF_W = 10;
  localparam int unsigned SETS   = 32;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned OUT_W  = 28;

  typedef struct packed {
    logic fwd_off;
    logic rev_off;
    logic acc_en;
  } ctl_t;
endpackage

// File: rtl/fcell_coef_bank.sv
module fcell_coef_bank #(
  parameter int unsigned COEF_W = fir_cell_pkg::COEF_W,
  parameter int unsigned SETS   = fir_cell_pkg::SETS,
  parameter int unsigned ADDR_W = fir_cell_pkg::ADDR_W,
  localparam int unsigned SELW  = $clog2(SETS)
) (
  input  logic              rst_ni,
  input  logic              wr_clk_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [COEF_W-1:0] wr_data_i,
  input  logic [SELW-1:0]   rd_sel_i,
  output logic [COEF_W-1:0] rd_coef_o
);
  logic [SETS-1:0][COEF_W-1:0] mem_q;
  logic hit;

  // upper address bits reserved; only the all-zero page maps onto the bank
  assign hit = (wr_addr_i[ADDR_W-1:SELW] == '0);

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (hit) mem_q[wr_addr_i[SELW-1:0]] <= wr_data_i;
  end

  assign rd_coef_o = mem_q[rd_sel_i];

  // R6
  ignored_write_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !hit |=> $stable(mem_q));
  // R5
  coef_write_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    hit |=> mem_q[$past(wr_addr_i[SELW-1:0])] == $past(wr_data_i));
endmodule

// File: rtl/fcell_premac.sv
module fcell_premac #(
  parameter int unsigned DATA_W = fir_cell_pkg::DATA_W,
  parameter int unsigned COEF_W = fir_cell_pkg::COEF_W,
  parameter int unsigned SETS   = fir_cell_pkg::SETS,
  localparam int unsigned SELW  = $clog2(SETS),
  localparam int unsigned SUM_W = DATA_W + 1,
  localparam int unsigned PROD_W = SUM_W + COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] fwd_i,
  input  logic [DATA_W-1:0] rev_i,
  input  logic              fwd_en_ni,
  input  logic              rev_en_ni,
  input  logic [SELW-1:0]   csel_i,
  input  logic              acc_en_i,
  output logic [SELW-1:0]   coef_sel_o,
  input  logic [COEF_W-1:0] coef_i,
  output logic [PROD_W-1:0] prod_o,
  output logic              acc_en_o
);
  import fir_cell_pkg::ctl_t;

  logic [DATA_W-1:0] fwd_q, rev_q;
  logic [SELW-1:0]   sel_q;
  ctl_t              ctl_q;
  logic [SUM_W-1:0]  op_a, op_b, sum_c;
  logic [PROD_W-1:0] prod_c, prod_q;
  logic              acc_en_q2;

  // stage 1: register every datapath/control input
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_q <= '0;
      rev_q <= '0;
      sel_q <= '0;
      ctl_q <= '{fwd_off: 1'b1, rev_off: 1'b1, acc_en: 1'b1};
    end else begin
      fwd_q <= fwd_i;
      rev_q <= rev_i;
      sel_q <= csel_i;
      ctl_q <= '{fwd_off: fwd_en_ni, rev_off: rev_en_ni, acc_en: acc_en_i};
    end
  end

  assign coef_sel_o = sel_q;
  assign op_a  = ctl_q.fwd_off ? '0 : {fwd_q[DATA_W-1], fwd_q};
  assign op_b  = ctl_q.rev_off ? '0 : {rev_q[DATA_W-1], rev_q};
  assign sum_c = op_a + op_b;
  // both operands sign-extended to product width; low PROD_W bits are exact
  assign prod_c = {{(PROD_W-SUM_W){sum_c[SUM_W-1]}}, sum_c}
                * {{(PROD_W-COEF_W){coef_i[COEF_W-1]}}, coef_i};

  // stage 2: product register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q    <= '0;
      acc_en_q2 <= 1'b1;
    end else begin
      prod_q    <= prod_c;
      acc_en_q2 <= ctl_q.acc_en;
    end
  end

  assign prod_o   = prod_q;
  assign acc_en_o = acc_en_q2;

  // R2 R3
  gated_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.fwd_off && ctl_q.rev_off) |=> prod_q == '0);
  // R11
  ctl_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> acc_en_q2 == $past(ctl_q.acc_en));
endmodule

// File: rtl/fcell_accum.sv
module fcell_accum #(
  parameter int unsigned PROD_W = 21,
  parameter int unsigned OUT_W  = fir_cell_pkg::OUT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PROD_W-1:0] prod_i,
  input  logic              acc_en_i,
  output logic [OUT_W-1:0]  res_o,
  output logic              vld_o
);
  logic [OUT_W-1:0] p_ext, acc_q, hold_q;
  logic             vld_q;

  assign p_ext = {{(OUT_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      hold_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= !acc_en_i;
      if (acc_en_i) begin
        acc_q <= acc_q + p_ext;
      end else begin
        hold_q <= acc_q;
        acc_q  <= p_ext;  // feedback zeroed: restart from this product
      end
    end
  end

  assign res_o = hold_q;
  assign vld_o = vld_q;

  // R8 R12
  accumulate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i |=> acc_q == $past(acc_q) + $past(p_ext));
  // R9
  dump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_en_i |=> (hold_q == $past(acc_q)) && (acc_q == $past(p_ext)));
  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i |=> $stable(hold_q) && !vld_q);
  // R10
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_en_i |=> vld_q);
endmodule

// File: rtl/fir_symcell.sv
module fir_symcell #(
  parameter int unsigned DATA_W = fir_cell_pkg::DATA_W,
  parameter int unsigned COEF_W = fir_cell_pkg::COEF_W,
  parameter int unsigned SETS   = fir_cell_pkg::SETS,
  parameter int unsigned ADDR_W = fir_cell_pkg::ADDR_W,
  parameter int unsigned OUT_W  = fir_cell_pkg::OUT_W,
  localparam int unsigned SELW  = $clog2(SETS),
  localparam int unsigned PROD_W = DATA_W + 1 + COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] fwd_i,
  input  logic [DATA_W-1:0] rev_i,
  input  logic              fwd_en_ni,
  input  logic              rev_en_ni,
  input  logic [SELW-1:0]   csel_i,
  input  logic              acc_en_i,
  input  logic              wr_clk_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [COEF_W-1:0] wr_data_i,
  output logic [OUT_W-1:0]  res_o,
  output logic              res_vld_o
);
  logic [SELW-1:0]   coef_sel;
  logic [COEF_W-1:0] coef;
  logic [PROD_W-1:0] prod;
  logic              acc_en_d;

  fcell_coef_bank #(.COEF_W(COEF_W), .SETS(SETS), .ADDR_W(ADDR_W)) u_bank (
    .rst_ni    (rst_ni),
    .wr_clk_i  (wr_clk_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (coef_sel),
    .rd_coef_o (coef)
  );

  fcell_premac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .SETS(SETS)) u_premac (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fwd_i      (fwd_i),
    .rev_i      (rev_i),
    .fwd_en_ni  (fwd_en_ni),
    .rev_en_ni  (rev_en_ni),
    .csel_i     (csel_i),
    .acc_en_i   (acc_en_i),
    .coef_sel_o (coef_sel),
    .coef_i     (coef),
    .prod_o     (prod),
    .acc_en_o   (acc_en_d)
  );

  fcell_accum #(.PROD_W(PROD_W), .OUT_W(OUT_W)) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .prod_i   (prod),
    .acc_en_i (acc_en_d),
    .res_o    (res_o),
    .vld_o    (res_vld_o)
  );
endmodule

// File: tb/sim_fir_symcell.sv
`timescale 1ns/1ps
module sim_fir_symcell;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  fwd_i = '0, rev_i = '0;
  logic        fwd_en_ni = 1'b1, rev_en_ni = 1'b1;
  logic [4:0]  csel_i = '0;
  logic        acc_en_i = 1'b1;
  logic        wr_clk_i = 1'b0;
  logic [8:0]  wr_addr_i = '0;
  logic [9:0]  wr_data_i = '0;
  logic [27:0] res_o;
  logic        res_vld_o;

  always #4 clk = ~clk;  // 125 MHz

  fir_symcell u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fwd_i(fwd_i), .rev_i(rev_i),
    .fwd_en_ni(fwd_en_ni), .rev_en_ni(rev_en_ni), .csel_i(csel_i),
    .acc_en_i(acc_en_i), .wr_clk_i(wr_clk_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .res_o(res_o), .res_vld_o(res_vld_o)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // vector: [31:22] fwd, [21:12] rev, [11] fwd_off, [10] rev_off, [9:5] csel, [4] acc_en
  function automatic logic [31:0] mk(int f, int r, bit fo, bit ro, int cs, bit ae);
    return {10'(f), 10'(r), fo, ro, 5'(cs), ae, 4'b0};
  endfunction

  localparam int NV = 16;
  localparam logic [31:0] VEC [NV] = '{
    mk(5, 3, 0, 0, 1, 0),      mk(-7, 2, 0, 0, 1, 1),
    mk(100, -100, 0, 1, 2, 1), mk(12, 34, 1, 0, 3, 1),
    mk(9, 9, 1, 1, 4, 1),      mk(511, 511, 0, 0, 30, 0),
    mk(-512, -512, 0, 0, 31, 1), mk(-512, 511, 0, 0, 31, 1),
    mk(200, -3, 0, 0, 7, 0),   mk(-1, -1, 0, 0, 8, 0),
    mk(1, 0, 0, 0, 9, 0),      mk(33, 44, 0, 0, 15, 1),
    mk(-300, 250, 0, 0, 0, 1), mk(77, -77, 0, 0, 16, 1),
    mk(0, 0, 1, 1, 0, 0),      mk(3, 4, 0, 0, 5, 1)
  };
  localparam logic [31:0] IDLE = {22'b0, 1'b1, 1'b1, 5'b0, 1'b1, 4'b0};
  localparam logic [31:0] DUMP = {22'b0, 1'b1, 1'b1, 5'b0, 1'b0, 4'b0};

  // reference model
  logic [9:0]  coef_m [32];
  logic [31:0] m_in;
  logic [27:0] m_prod, m_acc, m_hold;
  logic        m_pae, m_vld;

  function automatic logic [27:0] prod_m(logic [31:0] v);
    int a, b, c;
    a = v[11] ? 0 : int'($signed(v[31:22]));  // R2
    b = v[10] ? 0 : int'($signed(v[21:12]));  // R3
    c = int'($signed(coef_m[v[9:5]]));        // R7
    return 28'((a + b) * c);                  // R4
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) coef_m[i] = '0;
    m_in = IDLE; m_prod = '0; m_pae = 1'b1;
    m_acc = '0; m_hold = '0; m_vld = 1'b0;
  endtask

  task automatic model_step(logic [31:0] v);
    m_vld = 1'b0;
    if (m_pae) m_acc = m_acc + m_prod;                          // R8 R12
    else begin m_hold = m_acc; m_acc = m_prod; m_vld = 1'b1; end // R9 R10
    m_prod = prod_m(m_in);
    m_pae  = m_in[4];
    m_in   = v;
  endtask

  task automatic chk(string tag);
    checks++;
    if (res_o !== m_hold || res_vld_o !== m_vld) begin
      fails++;
      $display("FAIL %s: res=%0d vld=%0b expected res=%0d vld=%0b",
               tag, $signed(res_o), res_vld_o, $signed(m_hold), m_vld);
    end
  endtask

  task automatic tick(logic [31:0] v, string tag);
    @(negedge clk);
    fwd_i = v[31:22]; rev_i = v[21:12]; fwd_en_ni = v[11]; rev_en_ni = v[10];
    csel_i = v[9:5]; acc_en_i = v[4];
    @(posedge clk); #1;
    model_step(v);
    chk(tag);
  endtask

  task automatic wr(logic [8:0] a, logic [9:0] d);
    wr_addr_i = a; wr_data_i = d;
    #2 wr_clk_i = 1'b1;
    #2 wr_clk_i = 1'b0;
    if (a[8:5] == 4'd0) coef_m[a[4:0]] = d;  // R5, else R6
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset");
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1 chk("R1 after release");
    // coefficients still zero from reset: sums must dump as 0
    tick(mk(100, 50, 0, 0, 3, 0), "R1 zero coef");
    tick(mk(-20, 7, 0, 0, 9, 1), "R1 zero coef");
    tick(DUMP, "R1 zero coef");
    repeat (3) tick(IDLE, "R1 zero coef");

    for (int s = 0; s < 32; s++) wr(9'(s), 10'(s * 37 - 300));
    wr(9'd30, 10'd511);
    wr(9'd31, 10'h200);

    // vector table walk
    for (int i = 0; i < NV; i++) tick(VEC[i], "R2 R3 R4 R7 R8 R9 R11");
    repeat (3) tick(IDLE, "R10 idle");
    tick(DUMP, "R9 R11");
    repeat (3) tick(IDLE, "R10");

    // ignored write: page 5 aliasing set 2 must leave set 2 intact
    wr({4'h5, 5'd2}, 10'h155);
    tick(mk(10, 20, 0, 0, 2, 0), "R6");
    tick(mk(-40, 3, 0, 0, 2, 1), "R6");
    tick(DUMP, "R6");
    repeat (3) tick(IDLE, "R6");

    // wraparound: 600 products of 2^19
    tick(mk(-512, -512, 0, 0, 31, 0), "R12");
    repeat (599) tick(mk(-512, -512, 0, 0, 31, 1), "R12");
    tick(DUMP, "R12");
    tick(IDLE, "R12");
    tick(IDLE, "R12");
    checks++;
    if (res_o !== 28'd46137344 || res_vld_o !== 1'b1) begin
      fails++;
      $display("FAIL R12: res=%0d vld=%0b expected res=46137344 vld=1", res_o, res_vld_o);
    end
    repeat (2) tick(IDLE, "R10 after wrap");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule